// File: doc/BRIEF.md
# Hardware Cursor Overlay Merger

This block lays a 16x16 one-bit cursor pattern over a serial video bit stream. At the start of every field it takes a snapshot of the cursor's X and Y coordinates. At every line strobe, which marks horizontal retrace, it copies the field's X into the per-line hardware, clears its pixel counter and, when the current line falls inside the cursor's sixteen-line window, takes that line's pattern row from the row-load port. During the visible part of the line, each bit-clock enable moves the pixel counter forward by one. When the counter equals X, the row is shifted out most-significant bit first, one bit per enable, for sixteen pixels.

The merged bit is the display data ORed with the cursor bit and then inverted by the current band polarity, so the cursor always appears in the foreground colour. A line strobe that arrives outside any band leaves the polarity at its last value. Setting X to all ones hides the cursor. Once a line past the window has been seen, row loads stay blocked until the next field. The cursor geometry does not depend on the display resolution mode: the bit enable is always the full-rate pixel clock.

The memory side sees only two things. `row_req` tells it that a row is wanted for the line now shown on `line_num`, and `row_idx` tells it which of the sixteen pattern rows to supply.

Top module: `cursor_overlay`

## Requirements
- R1: After reset `video_out` is 0, X reads as all ones (cursor hidden) and the polarity is normal. Until the first field strobe, video passes through with no cursor.
- R2: `cur_x` and `cur_y` are captured only on a `field_start` pulse. Changes made between field strobes have no effect on the cursor.
- R3: While `line_num` − Y is in 0..15 and the passed flag is clear, `row_req` is 1 and `row_idx` equals `line_num` − Y. On `line_strobe` the pattern row is loaded from `row_data` when `row_req` is 1, and an empty row is loaded otherwise.
- R4: A `line_strobe` with `line_num` ≥ Y+16 sets a passed flag. While that flag is set, no row loads even for lines inside the window. `field_start` clears the flag.
- R5: Counting bit enables from 0 after the last `line_strobe`, pixels X through X+15 carry row bits 15 down to 0 in that order. All other pixels carry no cursor bit.
- R6: When the X captured for the field is all ones, no pixel carries a cursor bit.
- R7: On a cycle with `bit_en` high, `video_out` is registered as (`data_in` OR cursor bit) XOR polarity, one clock after the enable. In cycles without `bit_en`, `video_out` holds its value.
- R8: On `line_strobe` with `band_active` high, the polarity takes `band_inv` (1 means inverted). With `band_active` low, the previous polarity is kept.
- R9: The cursor advances exactly one bit per `bit_en` pulse. Idle cycles between pulses neither move nor stretch it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_start | input | 1 | One-cycle pulse at the start of a field; captures the coordinates |
| cur_x | input | XW | Cursor X coordinate; all ones hides the cursor |
| cur_y | input | YW | Cursor Y coordinate (top row of the pattern) |
| line_strobe | input | 1 | One-cycle pulse during horizontal retrace |
| line_num | input | YW | Number of the scan line about to be shown |
| row_data | input | CW | Cursor pattern row supplied by memory |
| band_active | input | 1 | The line belongs to a display band |
| band_inv | input | 1 | Polarity of that band, 1 = inverted |
| bit_en | input | 1 | Full-rate pixel bit clock enable |
| data_in | input | 1 | Display data bit for this pixel |
| row_req | output | 1 | A pattern row is wanted for `line_num` |
| row_idx | output | IW | Index of the wanted pattern row |
| video_out | output | 1 | Merged video bit |

## Verification
The bench targets the window edges: line Y−1, line Y, line Y+15 and line Y+16. A design with an off-by-one compare would draw a cursor seventeen lines tall or lose its last row. Lines near the top of the line number range are tested to catch a window sum that wraps. The bench revisits a window line after the passed flag has been set, which catches a flag that is never set or is cleared too early. It also changes X between field strobes, which catches coordinates that are not captured once per field.

X equal to all ones and X equal to 0 probe the hide code and the first-pixel match. Gapped bit enables expose a shifter that runs on the system clock instead of the pixel clock. Lines that lie outside every band check that the polarity is held rather than reset to normal.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CW = 16,
  parameter int XW = 10,
  parameter int YW = 10,
  localparam int IW = $clog2(CW),
  localparam int LW = $clog2(CW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_start,
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic          line_strobe,
  input  logic [YW-1:0] line_num,
  input  logic [CW-1:0] row_data,
  input  logic          band_active,
  input  logic          band_inv,
  input  logic          bit_en,
  input  logic          data_in,
  output logic          row_req,
  output logic [IW-1:0] row_idx,
  output logic          video_out
);
  localparam logic [YW:0]   CH   = (YW + 1)'(CW);
  localparam logic [LW-1:0] LAST = LW'(CW - 1);

  logic [XW-1:0] x_fld, x_line, xcnt;
  logic [YW-1:0] y_fld;
  logic          done, pol, vout;
  logic [CW-1:0] sreg;
  logic [LW-1:0] left;
  logic [YW:0]   diff;
  logic          ahead, past, hit, cbit;

  assign diff    = {1'b0, line_num} - {1'b0, y_fld};
  assign ahead   = diff[YW];
  assign past    = !ahead && (diff >= CH);
  assign row_req = !done && !ahead && !past;
  assign row_idx = diff[IW-1:0];

  assign hit  = (xcnt == x_line) && (x_line != '1) && (left == '0);
  assign cbit = (hit || left != '0) && sreg[CW-1];
  assign video_out = vout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_fld  <= '1;
      y_fld  <= '0;
      x_line <= '1;
      xcnt   <= '0;
      done   <= 1'b0;
      pol    <= 1'b0;
      sreg   <= '0;
      left   <= '0;
      vout   <= 1'b0;
    end else begin
      if (field_start) begin
        x_fld <= cur_x;
        y_fld <= cur_y;
        done  <= 1'b0;
      end
      if (line_strobe) begin
        x_line <= x_fld;
        xcnt   <= '0;
        left   <= '0;
        sreg   <= row_req ? row_data : '0;
        if (past) done <= 1'b1;
        if (band_active) pol <= band_inv;
      end else if (bit_en) begin
        if (xcnt != '1) xcnt <= xcnt + 1'b1;
        if (hit || left != '0) begin
          sreg <= sreg << 1;
          left <= hit ? LAST : left - 1'b1;
        end
      end
      if (bit_en) vout <= (data_in | cbit) ^ pol;
    end
  end
endmodule

module cursor_overlay_chk #(
  parameter int CW = 16,
  parameter int XW = 10,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          field_start,
  input logic          line_strobe,
  input logic          row_req,
  input logic          bit_en,
  input logic          data_in,
  input logic          video_out,
  input logic [XW-1:0] x_line,
  input logic [LW-1:0] left,
  input logic [CW-1:0] sreg,
  input logic          done,
  input logic          pol,
  input logic          cbit
);
  // R6
  hidden_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_line == '1) |-> (left == '0));

  // R4
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !line_strobe) |=> !done);

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(video_out));

  // R7
  plain_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !cbit) |=> (video_out == ($past(data_in) ^ $past(pol))));

  // R3
  empty_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && !row_req) |=> (sreg == '0 && left == '0));

  // R9
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !line_strobe && left != '0) |=> (left == $past(left) - 1'b1));
endmodule

bind cursor_overlay cursor_overlay_chk #(.CW(CW), .XW(XW), .LW(LW)) chk (
  .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_strobe(line_strobe),
  .row_req(row_req), .bit_en(bit_en), .data_in(data_in), .video_out(video_out),
  .x_line(x_line), .left(left), .sreg(sreg), .done(done), .pol(pol), .cbit(cbit)
);

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
  localparam int NPIX = 48;

  logic clk = 0, rst_n = 0;
  logic field_start = 0, line_strobe = 0, band_active = 0, band_inv = 0;
  logic bit_en = 0, data_in = 0;
  logic [9:0] cur_x = 0, cur_y = 0, line_num = 0;
  logic [15:0] row_data = 0;
  logic row_req, video_out;
  logic [3:0] row_idx;
  int checks = 0, errors = 0;
  logic pol_m = 0;

  always #4 clk = ~clk;

  cursor_overlay uut (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .cur_x(cur_x), .cur_y(cur_y),
    .line_strobe(line_strobe), .line_num(line_num), .row_data(row_data),
    .band_active(band_active), .band_inv(band_inv), .bit_en(bit_en), .data_in(data_in),
    .row_req(row_req), .row_idx(row_idx), .video_out(video_out)
  );

  // x(10) y(10) line(10) row(16) inv(1) pattern(1)
  localparam logic [47:0] VEC [10] = '{
    {10'd5,    10'd10,   10'd10,   16'hF00F, 1'b0, 1'b0},
    {10'd5,    10'd10,   10'd25,   16'h8001, 1'b0, 1'b0},
    {10'd5,    10'd10,   10'd26,   16'hFFFF, 1'b0, 1'b0},
    {10'd5,    10'd10,   10'd9,    16'hFFFF, 1'b0, 1'b0},
    {10'd0,    10'd3,    10'd7,    16'hA5C3, 1'b1, 1'b0},
    {10'd20,   10'd100,  10'd110,  16'h3C96, 1'b0, 1'b1},
    {10'd1023, 10'd4,    10'd4,    16'hFFFF, 1'b0, 1'b1},
    {10'd31,   10'd1015, 10'd1023, 16'h0F0F, 1'b1, 1'b1},
    {10'd12,   10'd1020, 10'd2,    16'hFFFF, 1'b0, 1'b0},
    {10'd2,    10'd0,    10'd15,   16'h1234, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit dbit(input bit pat, input int p);
    return pat ? (p % 3 == 0) : 1'b0;
  endfunction

  function automatic bit model(input int x, y, ln, input logic [15:0] row,
                               input bit inv, d, loaded, input int p);
    int dy = ln - y;
    bit c = 0;
    if (loaded && x != 1023 && dy >= 0 && dy < 16 && p >= x && p < x + 16)
      c = row[15 - (p - x)];
    return (d | c) ^ inv;
  endfunction

  task automatic field(input int x, y);
    @(negedge clk); cur_x = 10'(x); cur_y = 10'(y); field_start = 1;
    @(negedge clk); field_start = 0;
  endtask

  task automatic line(input int ln, input logic [15:0] row, input bit act, inv);
    @(negedge clk); line_num = 10'(ln); row_data = row; band_active = act; band_inv = inv;
    line_strobe = 1;
    if (act) pol_m = inv;
    @(negedge clk); line_strobe = 0;
  endtask

  // returns number of mismatching pixels; gap inserts idle cycles
  task automatic run(input int x, y, ln, input logic [15:0] row, input bit pat, loaded,
                     input bit gap, output int bad);
    bad = 0;
    for (int p = 0; p < NPIX; p++) begin
      data_in = dbit(pat, p); bit_en = 1;
      @(negedge clk); bit_en = 0;
      if (video_out !== model(x, y, ln, row, pol_m, dbit(pat, p), loaded, p)) bad++;
      if (gap) begin
        data_in = ~data_in;
        @(negedge clk);
        if (video_out !== model(x, y, ln, row, pol_m, dbit(pat, p), loaded, p)) bad++;
      end
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    // R1 reset output
    chk(video_out == 0, "R1 reset video", video_out, 0);
    rst_n = 1;
    // R1 hidden before first field
    line(0, 16'hFFFF, 1, 0);
    run(1023, 0, 0, 16'hFFFF, 0, 1, 0, bad);
    chk(bad == 0, "R1 no cursor before field", bad, 0);

    // table: R3 R4 R5 R6 R7 window and merge cases
    foreach (VEC[i]) begin
      int x, y, ln; logic [15:0] row; bit inv, pat;
      {x, y, ln, row, inv, pat} = {22'd0, VEC[i][47:38], 22'd0, VEC[i][37:28],
                                   22'd0, VEC[i][27:18], VEC[i][17:2], VEC[i][1], VEC[i][0]};
      x = VEC[i][47:38]; y = VEC[i][37:28]; ln = VEC[i][27:18];
      field(x, y);
      line(ln, row, 1, inv);
      run(x, y, ln, row, pat, 1, 0, bad);
      chk(bad == 0, $sformatf("R5 R3 R6 R7 vector %0d", i), bad, 0);
    end

    // R3 fetch index
    field(4, 10);
    @(negedge clk); line_num = 13;
    #1 chk(row_req == 1 && row_idx == 3, "R3 row_req/row_idx", {row_req, row_idx}, 5'h13);
    line_num = 26;
    #1 chk(row_req == 0, "R3 no req past window", row_req, 0);

    // R4 passed flag blocks until next field
    line(30, 16'hFFFF, 1, 0);
    line(12, 16'hFFFF, 1, 0);
    run(4, 10, 12, 16'hFFFF, 0, 0, 0, bad);
    chk(bad == 0, "R4 blocked after pass", bad, 0);
    field(4, 10);
    line(12, 16'hFFFF, 1, 0);
    run(4, 10, 12, 16'hFFFF, 0, 1, 0, bad);
    chk(bad == 0, "R4 reopened by field", bad, 0);

    // R2 X change without field strobe is ignored
    field(5, 0);
    @(negedge clk); cur_x = 9; cur_y = 40;
    line(2, 16'hC003, 1, 0);
    run(5, 0, 2, 16'hC003, 0, 1, 0, bad);
    chk(bad == 0, "R2 coordinates held", bad, 0);

    // R8 polarity held outside bands
    field(6, 0);
    line(1, 16'hF0F0, 1, 1);
    line(3, 16'h0FF0, 0, 0);
    chk(pol_m == 1, "R8 model polarity", pol_m, 1);
    run(6, 0, 3, 16'h0FF0, 1, 1, 0, bad);
    chk(bad == 0, "R8 polarity kept", bad, 0);
    line(4, 16'h0FF0, 1, 0);
    run(6, 0, 4, 16'h0FF0, 1, 1, 0, bad);
    chk(bad == 0, "R8 polarity restored", bad, 0);

    // R9 gapped bit enables, R7 hold between them
    field(3, 0);
    line(0, 16'hA5C3, 1, 0);
    run(3, 0, 0, 16'hA5C3, 1, 1, 1, bad);
    chk(bad == 0, "R9 R7 gapped enables", bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule